// File: doc/BRIEF.md
# Grouped Interrupt Controller with Summary

This block collects interrupt sources in four groups of `W` lines each: local bus, LPC, PCI/other, and non-maskable. Each input is first conditioned by a per-bit polarity setting. A per-bit trigger setting then makes it either a live level or a latched edge. The resulting request word stays visible to software before any masking, so a handler can take the lowest set bit as the source to serve.

A per-bit mask decides which requests reach the summary word. The summary word has one bit per group. The three ordinary groups are ORed onto one CPU interrupt line, and the non-maskable group drives a line of its own.

Software reaches every setting through a flat register port with a combinational read. The address is `{group, register}`, and the summary word sits at address 16. Writing a request word acknowledges latched edges: each 0 in the written data clears that bit.

Top module: `grp_intc`

## Requirements
- R1: After reset every mask word reads all ones, and every trigger and polarity word reads zero. Latched edges are cleared, so with inactive (high) sources every request word, the summary and both interrupt lines read zero.
- R2: A bit with trigger 0 is level-sensitive. Its request bit reads 1 while the input is at the active level and 0 otherwise, with no latching. Polarity 1 means active high and polarity 0 means active low.
- R3: A bit with trigger 1 is edge-sensitive. Its request bit sets one clock after the input reaches the active level: a rising edge with polarity 1, a falling edge with polarity 0. The bit stays set after the input returns to inactive.
- R4: Writing a group's request word (register 3) clears every edge-mode bit written as 0 and keeps every bit written as 1. Such writes have no effect on level-mode bits.
- R5: If an edge arrives in the same clock as a write that clears that bit, the bit ends up set.
- R6: A mask bit of 1 keeps its request out of the summary, and a mask bit of 0 lets it through. The request word shows the pending state whatever the mask holds.
- R7: Register map: address = group×4 + register. The groups are local bus = 0, LPC = 1, PCI/other = 2, non-maskable = 3. The registers are mask = 0, trigger = 1, polarity = 2, request = 3. Summary bit g is set when group g has an unmasked pending request. The summary reads at address 16, writes to it are ignored, and any other unused address reads zero.
- R8: `irq_cpu` is the OR of summary bits 0 to 2, and `irq_nmi` equals summary bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lb | input | W | Local bus group sources |
| src_lpc | input | W | LPC group sources |
| src_pci | input | W | PCI/other group sources |
| src_nmi | input | W | Non-maskable group sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wr_data | input | W | Write data |
| rd_data | output | W | Combinational read data |
| irq_cpu | output | 1 | CPU interrupt line |
| irq_nmi | output | 1 | Non-maskable interrupt line |

## Verification
The assertions assume that sources are already synchronous to `clk`. They also assume that an edge-mode request is only cleared by an explicit write to its own request address. The bench changes sources and bus signals only on falling edges. Every active pulse it drives lasts at least one full clock, so each edge is seen exactly once. During reset it holds all sources at the inactive level for active-low polarity, so that no edge is seen while trigger words change.

// File: rtl/grp_intc.sv
`timescale 1ns/1ps
module grp_intc #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_lb,
  input  logic [W-1:0]  src_lpc,
  input  logic [W-1:0]  src_pci,
  input  logic [W-1:0]  src_nmi,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          irq_cpu,
  output logic          irq_nmi
);
  localparam int NG = 4;
  localparam logic [AW-1:0] STAT_ADDR = AW'(NG * 4);

  logic [NG-1:0][W-1:0] src, mask, trig, pol, cond, prev, edgeq, edge_det, clr, req;
  logic [NG-1:0] summary;

  assign src = {src_nmi, src_pci, src_lpc, src_lb};

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam logic [AW-1:0] A_MASK = AW'(4 * g);
    localparam logic [AW-1:0] A_TRIG = AW'(4 * g + 1);
    localparam logic [AW-1:0] A_POL  = AW'(4 * g + 2);
    localparam logic [AW-1:0] A_REQ  = AW'(4 * g + 3);

    assign cond[g]     = ~(src[g] ^ pol[g]);
    assign edge_det[g] = cond[g] & ~prev[g] & trig[g];
    assign clr[g]      = (wr_en && addr == A_REQ) ? ~wr_data : '0;
    assign req[g]      = (trig[g] & edgeq[g]) | (~trig[g] & cond[g]);
    assign summary[g]  = |(req[g] & ~mask[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask[g]  <= '1;
        trig[g]  <= '0;
        pol[g]   <= '0;
        prev[g]  <= '0;
        edgeq[g] <= '0;
      end else begin
        prev[g]  <= cond[g];
        edgeq[g] <= trig[g] & ((edgeq[g] & ~clr[g]) | edge_det[g]);
        if (wr_en && addr == A_MASK) mask[g] <= wr_data;
        if (wr_en && addr == A_TRIG) trig[g] <= wr_data;
        if (wr_en && addr == A_POL)  pol[g]  <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == STAT_ADDR) begin
      rd_data[NG-1:0] = summary;
    end else if (addr < STAT_ADDR) begin
      case (addr[1:0])
        2'd0: rd_data = mask[addr[3:2]];
        2'd1: rd_data = trig[addr[3:2]];
        2'd2: rd_data = pol[addr[3:2]];
        default: rd_data = req[addr[3:2]];
      endcase
    end
  end

  assign irq_cpu = |summary[2:0];
  assign irq_nmi = summary[3];
endmodule

module grp_intc_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [3:0][W-1:0]   mask,
  input logic [3:0][W-1:0]   trig,
  input logic [3:0][W-1:0]   edgeq,
  input logic [3:0][W-1:0]   edge_det,
  input logic [3:0][W-1:0]   clr,
  input logic [3:0][W-1:0]   req,
  input logic                irq_cpu,
  input logic                irq_nmi
);
  p_reset_mask_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1));

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (($past(edgeq & ~clr & trig) & trig & ~edgeq) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (($past(edge_det) & ~edgeq) == '0));

  p_cpu_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (&mask[0] && &mask[1] && &mask[2]) |-> !irq_cpu);

  p_nmi_src_r8: assert property (@(posedge clk) disable iff (rst)
    irq_nmi |-> (req[3] != '0));
endmodule

bind grp_intc grp_intc_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mask(mask), .trig(trig), .edgeq(edgeq),
  .edge_det(edge_det), .clr(clr), .req(req),
  .irq_cpu(irq_cpu), .irq_nmi(irq_nmi)
);

// File: tb/sim_grp_intc.sv
`timescale 1ns/1ps
module sim_grp_intc;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] s [4];
  logic         wr_en = 1'b0;
  logic [4:0]   addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq_cpu, irq_nmi;
  int errs = 0, checks = 0;
  bit done = 0;

  grp_intc #(.W(W), .AW(5)) u0 (
    .clk(clk), .rst(rst), .src_lb(s[0]), .src_lpc(s[1]), .src_pci(s[2]),
    .src_nmi(s[3]), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_cpu(irq_cpu), .irq_nmi(irq_nmi)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    addr = a[4:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [W-1:0] v);
    addr = a[4:0];
    #0.5;
    v = rd_data;
  endtask

  task automatic summary_line;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: run did not finish");
    summary_line();
  end

  initial begin
    logic [W-1:0] v;
    for (int g = 0; g < 4; g++) s[g] = '1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    for (int g = 0; g < 4; g++) begin
      rd(g*4+0, v); chk("R1 mask", v, '1);
      rd(g*4+1, v); chk("R1 trigger", v, '0);
      rd(g*4+2, v); chk("R1 polarity", v, '0);
      rd(g*4+3, v); chk("R1 request", v, '0);
    end
    rd(16, v); chk("R1 summary", v, '0);
    chk("R1 irq_cpu", W'(irq_cpu), '0);
    chk("R1 irq_nmi", W'(irq_nmi), '0);
    rd(17, v); chk("R7 unused addr", v, '0);
    wr(16, '1);
    rd(16, v); chk("R7 summary write ignored", v, '0);

    for (int g = 0; g < 4; g++) begin
      for (int b = 0; b < W; b++) begin
        logic [W-1:0] one, idle;
        one = W'(1) << b;
        idle = ~one;
        // level, active high on bit b
        wr(g*4+2, one);
        wr(g*4+0, ~one);
        s[g] = idle; tick();
        rd(g*4+3, v); chk("R2 level inactive", v, '0);
        rd(16, v);    chk("R7 summary idle", v, '0);
        s[g] = '1; tick();
        rd(g*4+3, v); chk("R2 level active", v, one);
        rd(16, v);    chk("R7 summary bit", v, W'(1) << g);
        chk("R8 irq_cpu", W'(irq_cpu), W'(g < 3));
        chk("R8 irq_nmi", W'(irq_nmi), W'(g == 3));
        wr(g*4+3, '0);
        rd(g*4+3, v); chk("R4 level write no effect", v, one);
        wr(g*4+0, '1);
        rd(g*4+3, v); chk("R6 request unmasked view", v, one);
        rd(16, v);    chk("R6 masked summary", v, '0);
        chk("R8 irq_cpu masked", W'(irq_cpu), '0);
        chk("R8 irq_nmi masked", W'(irq_nmi), '0);
        // edge, rising
        s[g] = idle;
        wr(g*4+0, ~one);
        wr(g*4+1, one);
        tick();
        s[g] = '1; tick();
        s[g] = idle; tick();
        rd(g*4+3, v); chk("R3 rising edge latched", v, one);
        rd(16, v);    chk("R7 summary edge", v, W'(1) << g);
        wr(g*4+3, '1);
        rd(g*4+3, v); chk("R4 write one keeps", v, one);
        wr(g*4+3, ~one);
        rd(g*4+3, v); chk("R4 write zero clears", v, '0);
        rd(16, v);    chk("R4 summary after clear", v, '0);
        // edge coinciding with clear
        s[g] = '1; addr = 5'(g*4+3); wr_data = '0; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; s[g] = idle; tick();
        rd(g*4+3, v); chk("R5 set wins over clear", v, one);
        // falling edge with active-low polarity
        s[g] = '1; tick();
        wr(g*4+2, '0);
        wr(g*4+3, '0);
        tick();
        rd(g*4+3, v); chk("R4 cleared before falling test", v, '0);
        s[g] = idle; tick();
        s[g] = '1; tick();
        rd(g*4+3, v); chk("R3 falling edge latched", v, one);
        wr(g*4+3, '0);
        rd(g*4+3, v); chk("R4 falling edge cleared", v, '0);
        // restore
        wr(g*4+1, '0);
        wr(g*4+0, '1);
        tick();
        rd(g*4+3, v); chk("R2 restored idle", v, '0);
      end
    end
    summary_line();
  end
endmodule